// File: doc/BRIEF.md
# Polled Serial Transceiver with Fractional Baud Slots

This block is a byte-wide asynchronous serial port (one start bit, eight data bits sent least significant first, one stop bit, no parity) that software drives by polling. A small register file, reached through a selector, a write strobe and a read strobe, holds the line-control and mode-control settings, a status word, the transmit and receive holding registers, an integer baud divisor and a 16-bit slot mask.

Each bit period is split into 16 sub-ticks. Sub-tick `n` lasts `divisor + 1` clocks, plus one more clock when bit `n` of the slot mask is set. A fractional bit rate is reached this way without a fractional counter. The receiver watches for a falling edge on each sub-tick and confirms the start bit half a bit later. It then samples every data bit and the stop bit at their midpoints. Software writes a byte into the transmit holding register once the transmitter reports empty. It reads the receive holding register once the status word flags a waiting byte.

Top module: `uart_slot`

## Requirements
- R1: After reset the status word reads 0x0002 (transmitter empty, no byte waiting, no framing error) and the serial output is high.
- R2: One serial bit lasts exactly 16*(divisor+1) + popcount(slot mask) clocks. Sub-tick `n` is one clock longer when mask bit `n` is 1.
- R3: A frame drives the line low for one bit, then the eight data bits with the least significant bit first, then one high stop bit. The line is high whenever the transmitter is empty.
- R4: Status bit 1 drops in the clock after an accepted write to the transmit holding register. It rises again at the end of that frame's stop bit.
- R5: A write to the transmit holding register while status bit 1 is 0 is ignored. The exception is a write that lands in the clock in which the current frame finishes: that write is accepted and starts the next frame.
- R6: The receiver confirms a start bit at its midpoint and samples each data bit at its midpoint, least significant bit first. At the stop-bit midpoint it places the byte in the receive holding register and sets status bit 0.
- R7: A read of the receive holding register clears status bit 0 unless a new byte arrives in the same clock.
- R8: A low stop bit sets status bit 2 (framing error), and the byte is still delivered. Status bit 2 always reflects the most recent frame.
- R9: A low pulse on the receive input shorter than a quarter bit produces no byte.
- R10: Mode bits [3:2] = 01 enable the transmitter and mode bits [1:0] = 01 enable the receiver, so 0x5 enables both. The reset mode is 0. While the transmitter is disabled, writes to the transmit holding register are ignored. While the receiver is disabled, no byte is delivered.
- R11: Selector codes: 0 line control, 1 mode control, 2 status, 3 transmit holding, 4 receive holding, 5 divisor, 6 slot mask. Line control, mode control, divisor and slot mask read back what was written. Line control 0x3 denotes the only supported framing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 3 | Register selector |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effect on receive holding) |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the selected register, combinational |
| rxd | input | 1 | Serial receive input |
| txd | output | 1 | Serial transmit output |

## Verification
The end of a transmit frame and a fresh write to the transmit holding register can fall in the same clock. The new byte must then be taken and must not be lost between the finishing frame and the empty flag. The bench provokes this by holding the write strobe high with a second byte for the whole first frame. Every write during that frame must be ignored, and the one write in the completion clock must start the next frame. A scoreboard that decodes the serial line judges the result: it must see the first byte intact followed by the second byte, with status bit 1 still low afterwards.

// File: rtl/uart_slot_pkg.sv
package uart_slot_pkg;
  localparam int BYTE_W = 8;
  localparam int SUB_N  = 16;

  typedef enum logic [2:0] {
    SEL_LINE = 3'd0,
    SEL_MODE = 3'd1,
    SEL_STAT = 3'd2,
    SEL_TXH  = 3'd3,
    SEL_RXH  = 3'd4,
    SEL_DIV  = 3'd5,
    SEL_SLOT = 3'd6
  } regSel_e;

  // control -> datapath
  typedef struct packed {
    logic              txLoad;
    logic [BYTE_W-1:0] txByte;
    logic              rxEn;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic              txDone;
    logic              rxDone;
    logic [BYTE_W-1:0] rxByte;
    logic              rxFrameErr;
  } dpEvent_t;
endpackage

// File: rtl/uart_slot_baud.sv
module uart_slot_baud #(
  parameter int DIV_W = 16,
  parameter int SUB_N = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic [SUB_N-1:0] slotMask,
  output logic             tick
);
  localparam int IDX_W = $clog2(SUB_N);

  logic [DIV_W:0]   clkCnt;
  logic [IDX_W-1:0] subIdx;
  logic [DIV_W:0]   limit;

  assign limit = (DIV_W+1)'(divisor) + (DIV_W+1)'(slotMask[subIdx]);
  assign tick  = (clkCnt >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkCnt <= '0;
      subIdx <= '0;
    end else if (tick) begin
      clkCnt <= '0;
      subIdx <= subIdx + 1'b1;
    end else begin
      clkCnt <= clkCnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_slot_ctrl.sv
module uart_slot_ctrl
  import uart_slot_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  dpEvent_t          dpEv,
  output ctrlStrobe_t       ctrlStb,
  output logic [DIV_W-1:0]  divisor,
  output logic [SUB_N-1:0]  slotMask,
  output logic              txEmpty,
  output logic              rxReady
);
  logic [7:0]        lineReg, modeReg;
  logic [BYTE_W-1:0] txHold, rxHold;
  logic              frameErr;
  logic              txEnabled, txAccept, rxRead;

  assign txEnabled = (modeReg[3:2] == 2'b01);
  assign txAccept  = wrEn && (regSel == SEL_TXH) && txEnabled && (txEmpty || dpEv.txDone);
  assign rxRead    = rdEn && (regSel == SEL_RXH);

  assign ctrlStb.txLoad = txAccept;
  assign ctrlStb.txByte = wrData[BYTE_W-1:0];
  assign ctrlStb.rxEn   = (modeReg[1:0] == 2'b01);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineReg  <= '0;
      modeReg  <= '0;
      divisor  <= '0;
      slotMask <= '0;
      txHold   <= '0;
      rxHold   <= '0;
      txEmpty  <= 1'b1;
      rxReady  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (wrEn) begin
        case (regSel)
          SEL_LINE: lineReg  <= wrData[7:0];
          SEL_MODE: modeReg  <= wrData[7:0];
          SEL_DIV:  divisor  <= wrData[DIV_W-1:0];
          SEL_SLOT: slotMask <= wrData[SUB_N-1:0];
          default: ;
        endcase
      end
      if (txAccept) begin
        txHold  <= wrData[BYTE_W-1:0];
        txEmpty <= 1'b0;
      end else if (dpEv.txDone) begin
        txEmpty <= 1'b1;
      end
      if (dpEv.rxDone) begin
        rxReady  <= 1'b1;
        rxHold   <= dpEv.rxByte;
        frameErr <= dpEv.rxFrameErr;
      end else if (rxRead) begin
        rxReady <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      SEL_LINE: rdData[7:0]        = lineReg;
      SEL_MODE: rdData[7:0]        = modeReg;
      SEL_STAT: rdData[2:0]        = {frameErr, txEmpty, rxReady};
      SEL_TXH:  rdData[BYTE_W-1:0] = txHold;
      SEL_RXH:  rdData[BYTE_W-1:0] = rxHold;
      SEL_DIV:  rdData[DIV_W-1:0]  = divisor;
      SEL_SLOT: rdData[SUB_N-1:0]  = slotMask;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/uart_slot_dp.sv
module uart_slot_dp
  import uart_slot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  ctrlStrobe_t ctrlStb,
  input  logic        rxd,
  output logic        txd,
  output dpEvent_t    dpEv
);
  localparam int FRAME_BITS = BYTE_W + 2;
  localparam int CNT_W      = $clog2(SUB_N);
  localparam int TXB_W      = $clog2(FRAME_BITS);
  localparam int RXB_W      = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_SUB = CNT_W'(SUB_N - 1);
  localparam logic [CNT_W-1:0] HALF_SUB = CNT_W'(SUB_N/2 - 1);

  // transmit engine
  logic [FRAME_BITS-1:0] txShift;
  logic [CNT_W-1:0]      txCnt;
  logic [TXB_W-1:0]      txBit;
  logic                  txBusy, txArmed;

  assign dpEv.txDone = txBusy && txArmed && tick && (txCnt == LAST_SUB) &&
                       (txBit == TXB_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      txCnt   <= '0;
      txBit   <= '0;
      txBusy  <= 1'b0;
      txArmed <= 1'b0;
      txd     <= 1'b1;
    end else if (ctrlStb.txLoad) begin
      txShift <= {1'b1, ctrlStb.txByte, 1'b0};
      txCnt   <= '0;
      txBit   <= '0;
      txBusy  <= 1'b1;
      txArmed <= 1'b0;
    end else if (txBusy && tick) begin
      if (!txArmed) begin
        txArmed <= 1'b1;
        txd     <= txShift[0];
        txCnt   <= '0;
      end else if (txCnt == LAST_SUB) begin
        txCnt <= '0;
        if (txBit == TXB_W'(FRAME_BITS - 1)) begin
          txBusy <= 1'b0;
          txd    <= 1'b1;
        end else begin
          txBit   <= txBit + 1'b1;
          txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
          txd     <= txShift[1];
        end
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  // receive engine
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_e;
  rxState_e          rxState;
  logic              rxS1, rxS2;
  logic [CNT_W-1:0]  rxCnt;
  logic [RXB_W-1:0]  rxBit;
  logic [BYTE_W-1:0] rxShift;

  assign dpEv.rxByte = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxS1            <= 1'b1;
      rxS2            <= 1'b1;
      rxState         <= RX_IDLE;
      rxCnt           <= '0;
      rxBit           <= '0;
      rxShift         <= '0;
      dpEv.rxDone     <= 1'b0;
      dpEv.rxFrameErr <= 1'b0;
    end else begin
      rxS1        <= rxd;
      rxS2        <= rxS1;
      dpEv.rxDone <= 1'b0;
      if (tick) begin
        case (rxState)
          RX_IDLE: if (ctrlStb.rxEn && !rxS2) begin
            rxState <= RX_START;
            rxCnt   <= '0;
          end
          RX_START: if (rxCnt == HALF_SUB) begin
            rxCnt   <= '0;
            rxBit   <= '0;
            rxState <= rxS2 ? RX_IDLE : RX_DATA;
          end else rxCnt <= rxCnt + 1'b1;
          RX_DATA: if (rxCnt == LAST_SUB) begin
            rxCnt   <= '0;
            rxShift <= {rxS2, rxShift[BYTE_W-1:1]};
            if (rxBit == RXB_W'(BYTE_W - 1)) rxState <= RX_STOP;
            else rxBit <= rxBit + 1'b1;
          end else rxCnt <= rxCnt + 1'b1;
          RX_STOP: if (rxCnt == LAST_SUB) begin
            rxCnt           <= '0;
            dpEv.rxDone     <= 1'b1;
            dpEv.rxFrameErr <= !rxS2;
            rxState         <= RX_IDLE;
          end else rxCnt <= rxCnt + 1'b1;
          default: rxState <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_slot.sv
module uart_slot
  import uart_slot_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             rxd,
  output logic             txd
);
  ctrlStrobe_t      ctrlStb;
  dpEvent_t         dpEv;
  logic [DIV_W-1:0] divisor;
  logic [SUB_N-1:0] slotMask;
  logic             tick, txEmpty, rxReady;

  uart_slot_ctrl #(.REG_W(REG_W), .DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .dpEv(dpEv), .ctrlStb(ctrlStb),
    .divisor(divisor), .slotMask(slotMask), .txEmpty(txEmpty), .rxReady(rxReady)
  );

  uart_slot_baud #(.DIV_W(DIV_W), .SUB_N(SUB_N)) i_baud (
    .clk(clk), .rstN(rstN), .divisor(divisor), .slotMask(slotMask), .tick(tick)
  );

  uart_slot_dp i_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .ctrlStb(ctrlStb),
    .rxd(rxd), .txd(txd), .dpEv(dpEv)
  );
endmodule

// File: rtl/uart_slot_chk.sv
module uart_slot_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] regSel,
  input logic       wrEn,
  input logic       rdEn,
  input logic       txd,
  input logic       txEmpty,
  input logic       rxReady,
  input logic       txLoad,
  input logic       txDone,
  input logic       rxDone,
  input logic       txEn
);
  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txd); // R3

  AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 3'd3 && txEn && txEmpty) |=> !txEmpty); // R4

  AST_FINISH_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && !txLoad) |=> txEmpty); // R4

  AST_LOAD_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> !txEmpty); // R5

  AST_RX_READY_SET: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> rxReady); // R6

  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == 3'd4 && !rxDone) |=> !rxReady); // R7
endmodule

bind uart_slot uart_slot_chk i_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
  .txd(txd), .txEmpty(txEmpty), .rxReady(rxReady),
  .txLoad(ctrlStb.txLoad), .txDone(dpEv.txDone), .rxDone(dpEv.rxDone),
  .txEn(i_ctrl.txEnabled)
);

// File: tb/test_uart_slot.sv
module test_uart_slot;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regSel = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        rxd = 1'b1;
  logic        txd;

  int nRun = 0, nFail = 0;
  int bitLen = 48;
  logic [7:0] expQ[$];

  always #5 clk = ~clk;

  uart_slot i_uart_slot (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .rxd(rxd), .txd(txd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk); regSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] sel, output logic [15:0] d);
    @(negedge clk); regSel = sel; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic setBaud(input logic [15:0] dv, input logic [15:0] mask);
    regWrite(3'd5, dv);
    regWrite(3'd6, mask);
    bitLen = 16 * (int'(dv) + 1) + $countones(mask);
  endtask

  // driver: wait for empty, write, push expected byte
  task automatic sendTx(input logic [7:0] b);
    logic [15:0] st;
    do regRead(3'd2, st); while (st[1] !== 1'b1);
    expQ.push_back(b);
    regWrite(3'd3, {8'h00, b});
  endtask

  task automatic rxSend(input logic [7:0] b, input logic stopVal);
    @(negedge clk); rxd = 1'b0;
    repeat (bitLen) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bitLen) @(negedge clk);
    end
    rxd = stopVal;
    repeat (bitLen) @(negedge clk);
    rxd = 1'b1;
    repeat (bitLen) @(negedge clk);
  endtask

  // monitor: decode serial line and compare against the scoreboard
  initial begin
    logic [7:0] got, exp;
    forever begin
      @(negedge clk);
      if (rstN && txd === 1'b0) begin
        repeat (bitLen / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (bitLen) @(negedge clk);
          got[i] = txd;
        end
        repeat (bitLen) @(negedge clk);
        check("R3 stop bit high", {31'b0, txd}, 32'h1);
        if (expQ.size() == 0) check("R3 unexpected frame", {24'b0, got}, 32'hFFFF_FFFF);
        else begin
          exp = expQ.pop_front();
          check("R3 frame byte LSB first", {24'b0, got}, {24'b0, exp});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [15:0] st, d;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regRead(3'd2, st);
    check("R1 status after reset", {16'b0, st}, 32'h2);
    check("R1 txd idle high", {31'b0, txd}, 32'h1);

    // mode 0: transmitter and receiver disabled
    setBaud(16'd2, 16'hDDDD);
    regWrite(3'd3, 16'h0055);
    regRead(3'd2, st);
    check("R10 tx write ignored when disabled", {31'b0, st[1]}, 32'h1);
    repeat (2 * bitLen) @(negedge clk);
    check("R10 line stays idle when disabled", {31'b0, txd}, 32'h1);
    rxSend(8'h5A, 1'b1);
    regRead(3'd2, st);
    check("R10 no byte while rx disabled", {31'b0, st[0]}, 32'h0);

    // enable, register readback
    regWrite(3'd0, 16'h0003);
    regWrite(3'd1, 16'h0005);
    regRead(3'd0, d); check("R11 line control readback", {16'b0, d}, 32'h3);
    regRead(3'd1, d); check("R11 mode readback", {16'b0, d}, 32'h5);
    regRead(3'd5, d); check("R11 divisor readback", {16'b0, d}, 32'h2);
    regRead(3'd6, d); check("R11 slot mask readback", {16'b0, d}, 32'hDDDD);

    // transmit with empty-flag handling
    sendTx(8'hA5);
    regRead(3'd2, st);
    check("R4 empty clears after write", {31'b0, st[1]}, 32'h0);
    wait (expQ.size() == 0);
    repeat (bitLen) @(negedge clk);
    regRead(3'd2, st);
    check("R4 empty sets after stop bit", {31'b0, st[1]}, 32'h1);
    sendTx(8'h3C);
    wait (expQ.size() == 0);
    repeat (bitLen) @(negedge clk);

    // bit period: 0x00 keeps the line low for start + 8 data bits
    setBaud(16'd2, 16'h0000);
    sendTx(8'h00);
    do @(negedge clk); while (txd !== 1'b0);
    cnt = 0;
    while (txd === 1'b0) begin cnt++; @(negedge clk); end
    check("R2 bit period mask 0000", cnt, 9 * 48);
    wait (expQ.size() == 0); repeat (bitLen) @(negedge clk);

    setBaud(16'd34, 16'hDDDD);
    sendTx(8'h00);
    do @(negedge clk); while (txd !== 1'b0);
    cnt = 0;
    while (txd === 1'b0) begin cnt++; @(negedge clk); end
    check("R2 bit period div 34 mask DDDD", cnt, 9 * 572);
    wait (expQ.size() == 0); repeat (bitLen) @(negedge clk);

    // write in the completion clock: hold wrEn for the whole first frame
    setBaud(16'd2, 16'hDDDD);
    sendTx(8'hC3);
    expQ.push_back(8'h96);
    @(negedge clk); regSel = 3'd3; wrData = 16'h0096; wrEn = 1'b1;
    repeat (10 * bitLen + bitLen / 2) @(negedge clk);
    wrEn = 1'b0;
    regRead(3'd2, st);
    check("R5 completion-clock write accepted", {31'b0, st[1]}, 32'h0);
    wait (expQ.size() == 0);
    repeat (bitLen) @(negedge clk);
    regRead(3'd3, d);
    check("R5 holding register has second byte", {16'b0, d}, 32'h96);

    // receive
    rxSend(8'hA5, 1'b1);
    regRead(3'd2, st);
    check("R6 byte waiting flag", {29'b0, st[2:0]}, 32'h3);
    regRead(3'd4, d);
    check("R6 received byte", {16'b0, d}, 32'hA5);
    regRead(3'd2, st);
    check("R7 read clears waiting flag", {31'b0, st[0]}, 32'h0);
    rxSend(8'h01, 1'b1);
    regRead(3'd4, d);
    check("R6 received byte 01", {16'b0, d}, 32'h01);

    rxSend(8'h3C, 1'b0);
    regRead(3'd2, st);
    check("R8 framing error flagged", {29'b0, st[2:0]}, 32'h7);
    regRead(3'd4, d);
    check("R8 byte still delivered", {16'b0, d}, 32'h3C);
    rxSend(8'h81, 1'b1);
    regRead(3'd2, st);
    check("R8 error cleared by good frame", {31'b0, st[2]}, 32'h0);
    regRead(3'd4, d);

    // short glitch on the receive line
    @(negedge clk); rxd = 1'b0;
    repeat (bitLen / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * bitLen) @(negedge clk);
    regRead(3'd2, st);
    check("R9 glitch yields no byte", {31'b0, st[0]}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule